// File: doc/BRIEF.md
# Synthetic Mesh Traffic Source

This block is the traffic source for one node of a 2D mesh network emulator. In every emulation cycle it advances a 32-bit xorshift generator and compares the low random bits with a programmed injection rate. When the draw falls below the rate, the block may start a new packet. The destination comes from one of three synthetic patterns, chosen by a pattern select input. The block also works out the first hop the source router must take under XY routing and places it in the head flit.

A packet is written into a local 16-entry source queue one flit per cycle. It starts with a head flit, carries a parameterised number of body flits and ends with a tail flit. The queue drains toward the router through a valid/ready stream. While `flit_ready_i` is low, a flit that has been offered stays put and keeps the same bits. A flit leaves only in a cycle where valid and ready are both high. When the queue cannot hold a whole packet, new packets are held back, and this is how the source throttles itself when the network is congested.

Each packet carries an 8-bit ID. When its head flit is accepted, the block raises a one-cycle record that gives the ID and the cycle count since reset, so that a sink can compute latency.

Top module: `noc_tgen`

## Requirements
- R1: While reset is asserted, `flit_valid_o` and `inj_valid_o` are low. After reset the generator state equals the node seed, and the first packet gets ID 0.
- R2: The random state advances in every cycle after reset with s^=s<<13, s^=s>>17, s^=s<<5. A packet may start only in a cycle where state[15:0] < `rate_i`, so a rate of 0 never starts a packet.
- R3: Pattern codes: 0 selects uniform random, with destination x = state[23:16] mod 5 and y = state[31:24] mod 5. Code 1 selects bit complement, (4−x, 4−y). Code 2 selects transpose, with x and y swapped.
- R4: No packet starts in a cycle where the destination equals the node itself, or while the pattern code is 3 (idle).
- R5: The head flit carries the first hop under XY routing, coded L=0, N=1, E=2, S=3, W=4. The x difference is resolved first: E if the destination x is larger, W if it is smaller. Then y decides: N if larger, S if smaller. Head info layout: [14:12] hop, [11:9] dest x, [8:6] dest y, [5:3] src x, [2:0] src y, [15]=0.
- R6: Flit layout: [25:24] kind (1 head, 2 body, 3 tail), [23:16] packet ID, [15:0] info. A packet is one head, then BODY_FLITS body flits whose info holds the sequence number 1..BODY_FLITS, then a tail whose info holds BODY_FLITS+1.
- R7: Packet IDs increase by one for each packet started, modulo 256.
- R8: While a packet is being written (one flit per cycle), no new injection decision is taken. The next decision comes in the cycle after the tail is written.
- R9: A packet starts only if the queue holds at most 16 − (BODY_FLITS+2) flits, so the queue never overflows.
- R10: While `flit_valid_o` is high and `flit_ready_i` is low, the offered flit stays valid and its bits stay unchanged.
- R11: In a cycle where a head flit is accepted, `inj_valid_o` is high, `inj_pid_o` carries its ID and `inj_time_o` carries the number of cycles since reset. In every other cycle `inj_valid_o` is low.
- R12: Flits leave the queue in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Emulation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_i | input | 16 | Injection threshold compared with the low random bits |
| pattern_i | input | 2 | Destination pattern: 0 uniform, 1 bit complement, 2 transpose, 3 idle |
| flit_valid_o | output | 1 | A flit is offered to the router |
| flit_ready_i | input | 1 | The router accepts the offered flit |
| flit_data_o | output | 26 | Offered flit: kind, packet ID, info |
| inj_valid_o | output | 1 | A head flit is accepted in this cycle |
| inj_pid_o | output | 8 | ID of the packet being injected |
| inj_time_o | output | 16 | Cycle count at injection |

## Verification
The bench predicts every flit from the xorshift sequence, rate, pattern and node position. The target corner cases follow:
- An off-by-one in the busy window would draw on the wrong random state, and every later packet would then mismatch.
- A wrong bit-complement or transpose mapping, or a hop chosen in y before x, shows up as wrong head fields. A second node on the diagonal must stay silent under both patterns; a design that skips the self-destination test would emit packets there.
- With ready held low the queue must fill with exactly four whole packets. A wrong room test would overflow the queue or stop early, and a queue that changes the offered flit while stalled breaks the hold rule.

// File: rtl/noc_tg_pkg.sv
package noc_tg_pkg;

  typedef enum logic [1:0] {
    FT_NONE = 2'd0,
    FT_HEAD = 2'd1,
    FT_BODY = 2'd2,
    FT_TAIL = 2'd3
  } flit_kind_e;

  typedef enum logic [2:0] {
    DIR_L = 3'd0,
    DIR_N = 3'd1,
    DIR_E = 3'd2,
    DIR_S = 3'd3,
    DIR_W = 3'd4
  } out_dir_e;

  typedef enum logic [1:0] {
    PAT_UNIFORM   = 2'd0,
    PAT_BITCOMP   = 2'd1,
    PAT_TRANSPOSE = 2'd2,
    PAT_OFF       = 2'd3
  } pattern_e;

  localparam int unsigned INFO_W = 16;
  localparam int unsigned KIND_W = 2;

endpackage

// File: rtl/noc_tg_xorshift.sv
module noc_tg_xorshift #(
  parameter logic [31:0] SEED = 32'h1234_5678
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] rnd_o
);
  // A zero state would lock the generator, so substitute a fixed nonzero one
  localparam logic [31:0] SEED_NZ = (SEED == 32'd0) ? 32'h0000_0001 : SEED;

  logic [31:0] state_q;
  logic [31:0] mix_a, mix_b, mix_c;

  always_comb begin
    mix_a = state_q ^ (state_q << 13);
    mix_b = mix_a ^ (mix_a >> 17);
    mix_c = mix_b ^ (mix_b << 5);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED_NZ;
    else        state_q <= mix_c;
  end

  assign rnd_o = state_q;
endmodule

// File: rtl/noc_tg_dest.sv
module noc_tg_dest
  import noc_tg_pkg::*;
#(
  parameter int MESH_DIM = 5,
  parameter int COORD_W  = 3,
  parameter int SRC_X    = 0,
  parameter int SRC_Y    = 0
) (
  input  pattern_e             pattern_i,
  input  logic [15:0]          rnd_hi_i,
  output logic [COORD_W-1:0]   dst_x_o,
  output logic [COORD_W-1:0]   dst_y_o,
  output out_dir_e             dir_o,
  output logic                 is_self_o
);
  localparam int                 MAXC = MESH_DIM - 1;
  localparam logic [COORD_W-1:0] SX   = COORD_W'(SRC_X);
  localparam logic [COORD_W-1:0] SY   = COORD_W'(SRC_Y);
  localparam logic [COORD_W-1:0] CX   = COORD_W'(MAXC - SRC_X);
  localparam logic [COORD_W-1:0] CY   = COORD_W'(MAXC - SRC_Y);

  logic [7:0] rx, ry;
  assign rx = rnd_hi_i[7:0]  % 8'(MESH_DIM);
  assign ry = rnd_hi_i[15:8] % 8'(MESH_DIM);

  always_comb begin
    unique case (pattern_i)
      PAT_BITCOMP: begin
        dst_x_o = CX;
        dst_y_o = CY;
      end
      PAT_TRANSPOSE: begin
        dst_x_o = SY;
        dst_y_o = SX;
      end
      default: begin
        dst_x_o = COORD_W'(rx);
        dst_y_o = COORD_W'(ry);
      end
    endcase
  end

  // Dimension-ordered: x settles before y
  always_comb begin
    if (dst_x_o > SX)      dir_o = DIR_E;
    else if (dst_x_o < SX) dir_o = DIR_W;
    else if (dst_y_o > SY) dir_o = DIR_N;
    else if (dst_y_o < SY) dir_o = DIR_S;
    else                   dir_o = DIR_L;
  end

  assign is_self_o = (dst_x_o == SX) && (dst_y_o == SY);
endmodule

// File: rtl/noc_tg_fifo.sv
module noc_tg_fifo #(
  parameter  int W     = 26,
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic          nonempty_o,
  output logic [CW-1:0] level_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign do_push = push_i && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout_o     = mem[rp_q];
  assign nonempty_o = (cnt_q != '0);
  assign level_o    = cnt_q;
endmodule

// File: rtl/noc_tgen.sv
module noc_tgen
  import noc_tg_pkg::*;
#(
  parameter  int          MESH_DIM   = 5,
  parameter  int          COORD_W    = 3,
  parameter  int          NODE_X     = 2,
  parameter  int          NODE_Y     = 3,
  parameter  logic [31:0] SEED       = 32'h1234_5678,
  parameter  int          BODY_FLITS = 2,
  parameter  int          QDEPTH     = 16,
  parameter  int          PID_W      = 8,
  parameter  int          TS_W       = 16,
  parameter  int          RATE_W     = 16,
  localparam int          FLIT_W     = KIND_W + PID_W + INFO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [1:0]        pattern_i,
  output logic              flit_valid_o,
  input  logic              flit_ready_i,
  output logic [FLIT_W-1:0] flit_data_o,
  output logic              inj_valid_o,
  output logic [PID_W-1:0]  inj_pid_o,
  output logic [TS_W-1:0]   inj_time_o
);
  localparam int PKT_LEN = BODY_FLITS + 2;
  localparam int LW      = $clog2(PKT_LEN + 1);
  localparam int LVL_W   = $clog2(QDEPTH + 1);
  localparam int ROOM    = QDEPTH - PKT_LEN;

  // ---------------- random source and destination ----------------
  logic [31:0]          rnd;
  pattern_e             pat;
  logic [COORD_W-1:0]   dst_x, dst_y;
  out_dir_e             dir;
  logic                 is_self;

  assign pat = pattern_e'(pattern_i);

  noc_tg_xorshift #(.SEED(SEED)) u_rng (
    .clk   (clk),
    .rst_n (rst_n),
    .rnd_o (rnd)
  );

  noc_tg_dest #(
    .MESH_DIM (MESH_DIM),
    .COORD_W  (COORD_W),
    .SRC_X    (NODE_X),
    .SRC_Y    (NODE_Y)
  ) u_dest (
    .pattern_i (pat),
    .rnd_hi_i  (rnd[31:16]),
    .dst_x_o   (dst_x),
    .dst_y_o   (dst_y),
    .dir_o     (dir),
    .is_self_o (is_self)
  );

  // ---------------- injection decision ----------------
  logic [LVL_W-1:0] q_level;
  logic [LW-1:0]    left_q, seq_q;
  logic             busy, fire, room, gen_start;

  assign busy      = (left_q != '0);
  assign fire      = (rnd[RATE_W-1:0] < rate_i);
  assign room      = (int'(q_level) <= ROOM);
  assign gen_start = !busy && room && (pat != PAT_OFF) && fire && !is_self;

  // ---------------- packet builder ----------------
  logic [PID_W-1:0]  pid_q, bld_pid_q;
  logic [INFO_W-1:0] head_info;
  logic [FLIT_W-1:0] wr_flit;
  logic              wr_en;

  assign head_info = INFO_W'({dir, dst_x, dst_y,
                              COORD_W'(NODE_X), COORD_W'(NODE_Y)});

  always_comb begin
    if (gen_start)
      wr_flit = {FT_HEAD, pid_q, head_info};
    else if (left_q == LW'(1))
      wr_flit = {FT_TAIL, bld_pid_q, INFO_W'(seq_q)};
    else
      wr_flit = {FT_BODY, bld_pid_q, INFO_W'(seq_q)};
  end

  assign wr_en = gen_start || busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q    <= '0;
      seq_q     <= '0;
      pid_q     <= '0;
      bld_pid_q <= '0;
    end else if (gen_start) begin
      left_q    <= LW'(PKT_LEN - 1);
      seq_q     <= LW'(1);
      bld_pid_q <= pid_q;
      pid_q     <= pid_q + PID_W'(1);
    end else if (busy) begin
      left_q <= left_q - LW'(1);
      seq_q  <= seq_q + LW'(1);
    end
  end

  // ---------------- source queue and stream side ----------------
  logic q_nonempty;
  logic hs;

  noc_tg_fifo #(.W(FLIT_W), .DEPTH(QDEPTH)) u_q (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (wr_en),
    .din_i      (wr_flit),
    .pop_i      (flit_ready_i),
    .dout_o     (flit_data_o),
    .nonempty_o (q_nonempty),
    .level_o    (q_level)
  );

  assign flit_valid_o = q_nonempty;
  assign hs           = flit_valid_o && flit_ready_i;

  // ---------------- injection record ----------------
  logic [TS_W-1:0] ts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= ts_q + TS_W'(1);
  end

  assign inj_valid_o = hs && (flit_data_o[FLIT_W-1 -: KIND_W] == FT_HEAD);
  assign inj_pid_o   = flit_data_o[INFO_W +: PID_W];
  assign inj_time_o  = ts_q;

endmodule

// File: rtl/noc_tgen_chk.sv
module noc_tgen_chk
  import noc_tg_pkg::*;
#(
  parameter int FLIT_W  = 26,
  parameter int QDEPTH  = 16,
  parameter int PKT_LEN = 4,
  parameter int LVL_W   = 5,
  parameter int RATE_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flit_valid_o,
  input logic              flit_ready_i,
  input logic [FLIT_W-1:0] flit_data_o,
  input logic [1:0]        pattern_i,
  input logic [RATE_W-1:0] rate_i,
  input logic              start_i,
  input logic [LVL_W-1:0]  level_i
);
  logic [1:0] kind;
  logic       hs;
  logic       open_q;

  assign kind = flit_data_o[FLIT_W-1 -: 2];
  assign hs   = flit_valid_o && flit_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       open_q <= 1'b0;
    else if (hs && kind == FT_HEAD)   open_q <= 1'b1;
    else if (hs && kind == FT_TAIL)   open_q <= 1'b0;
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid_o && !flit_ready_i |=> flit_valid_o && $stable(flit_data_o));

  // R6
  head_after_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs && kind == FT_HEAD |-> !open_q);

  // R6
  body_inside_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs && (kind == FT_BODY || kind == FT_TAIL) |-> open_q);

  // R6
  kind_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid_o |-> kind != FT_NONE);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pattern_i == PAT_OFF |-> !start_i);

  // R2
  rate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_i == '0 |-> !start_i);

  // R9
  room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> int'(level_i) <= QDEPTH - PKT_LEN);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level_i) <= QDEPTH);

endmodule

bind noc_tgen noc_tgen_chk #(
  .FLIT_W  (FLIT_W),
  .QDEPTH  (QDEPTH),
  .PKT_LEN (PKT_LEN),
  .LVL_W   (LVL_W),
  .RATE_W  (RATE_W)
) u_noc_tgen_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flit_valid_o (flit_valid_o),
  .flit_ready_i (flit_ready_i),
  .flit_data_o  (flit_data_o),
  .pattern_i    (pattern_i),
  .rate_i       (rate_i),
  .start_i      (gen_start),
  .level_i      (q_level)
);

// File: tb/noc_tgen_bench.sv
`timescale 1ns/1ps
module noc_tgen_bench;
  import noc_tg_pkg::*;

  localparam int          NX    = 2;
  localparam int          NY    = 3;
  localparam logic [31:0] SEED  = 32'h1234_5678;
  localparam int          BODY  = 2;
  localparam int          PLEN  = BODY + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] rate = '0;
  logic [1:0]  pattern = 2'd3;
  logic        ready = 1'b0;

  logic        f_valid, d_valid;
  logic [25:0] f_data, d_data;
  logic        inj_valid, d_inj_valid;
  logic [7:0]  inj_pid, d_inj_pid;
  logic [15:0] inj_time, d_inj_time;

  always #2 clk = ~clk;

  noc_tgen #(.NODE_X(NX), .NODE_Y(NY), .SEED(SEED), .BODY_FLITS(BODY)) u_noc_tgen (
    .clk(clk), .rst_n(rst_n), .rate_i(rate), .pattern_i(pattern),
    .flit_valid_o(f_valid), .flit_ready_i(ready), .flit_data_o(f_data),
    .inj_valid_o(inj_valid), .inj_pid_o(inj_pid), .inj_time_o(inj_time));

  noc_tgen #(.NODE_X(2), .NODE_Y(2), .SEED(32'h0BAD_CAFE), .BODY_FLITS(BODY)) u_noc_tgen_diag (
    .clk(clk), .rst_n(rst_n), .rate_i(rate), .pattern_i(pattern),
    .flit_valid_o(d_valid), .flit_ready_i(ready), .flit_data_o(d_data),
    .inj_valid_o(d_inj_valid), .inj_pid_o(d_inj_pid), .inj_time_o(d_inj_time));

  int n_cmp = 0, n_bad = 0;
  int hs_count = 0, thr_flits = 0, thr_heads = 0, diag_hits = 0;
  int cur_step = 0, nstep = 0;
  bit sb_on = 1'b1, diag_watch = 1'b0, done = 1'b0;
  logic [25:0] exp_q[$];

  logic [31:0] m_rng = SEED;
  int          m_busy = 0;
  logic [7:0]  m_pid = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  // Driver-side model: push the flits one node is expected to emit
  task automatic model_step();
    int dx, dy;
    logic [2:0] dir;
    cur_step = nstep;
    nstep++;
    if (m_busy > 0) m_busy--;
    else if (pattern != 2'd3 && m_rng[15:0] < rate) begin
      case (pattern)
        2'd1:    begin dx = 4 - NX; dy = 4 - NY; end
        2'd2:    begin dx = NY; dy = NX; end
        default: begin dx = int'(m_rng[23:16]) % 5; dy = int'(m_rng[31:24]) % 5; end
      endcase
      if (!(dx == NX && dy == NY)) begin
        if (dx > NX)      dir = 3'd2;
        else if (dx < NX) dir = 3'd4;
        else if (dy > NY) dir = 3'd1;
        else              dir = 3'd3;
        if (sb_on) begin
          exp_q.push_back({2'd1, m_pid, 1'b0, dir, 3'(dx), 3'(dy), 3'(NX), 3'(NY)});
          for (int k = 1; k <= BODY; k++) exp_q.push_back({2'd2, m_pid, 16'(k)});
          exp_q.push_back({2'd3, m_pid, 16'(BODY + 1)});
        end
        m_pid  = m_pid + 8'd1;
        m_busy = PLEN - 1;
      end
    end
    m_rng = xs(m_rng);
  endtask

  task automatic run(input int n, input logic [15:0] r, input logic [1:0] p, input logic rdy);
    repeat (n) begin
      @(negedge clk);
      rst_n   = 1'b1;
      rate    = r;
      pattern = p;
      ready   = rdy;
      model_step();
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Monitor: pops expectations as flits are accepted
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (f_valid && ready) begin
          hs_count++;
          if (sb_on) begin
            if (exp_q.size() == 0) begin
              chk(1'b0, "R12 flit with nothing expected", 32'(f_data), 32'h0);
            end else begin
              logic [25:0] e;
              e = exp_q.pop_front();
              if (e[25:24] == 2'd1)
                chk(f_data == e, "R5 head flit (dest R3, pid R7, timing R8)", 32'(f_data), 32'(e));
              else
                chk(f_data == e, "R6 body/tail flit in order R12", 32'(f_data), 32'(e));
            end
            if (f_data[25:24] == 2'd1) begin
              chk(inj_valid == 1'b1, "R11 record strobe on head", 32'(inj_valid), 32'd1);
              chk(inj_time == 16'(cur_step), "R11 record time", 32'(inj_time), 32'(cur_step));
              chk(inj_pid == f_data[23:16], "R11 record pid", 32'(inj_pid), 32'(f_data[23:16]));
            end else begin
              chk(inj_valid == 1'b0, "R11 no record on body/tail", 32'(inj_valid), 32'd0);
            end
          end else begin
            thr_flits++;
            if (f_data[25:24] == 2'd1) thr_heads++;
          end
        end
        if (diag_watch && d_valid) diag_hits++;
      end
    end
  end

  initial begin
    #400000;
    chk(1'b0, "R10 watchdog expired", 32'd0, 32'd1);
    finish_up();
  end

  initial begin
    int h0;
    logic [25:0] held;
    // R1: reset state
    repeat (4) begin
      @(negedge clk);
      #1;
      chk(f_valid == 1'b0, "R1 valid low in reset", 32'(f_valid), 32'd0);
      chk(inj_valid == 1'b0, "R1 record low in reset", 32'(inj_valid), 32'd0);
    end

    // R2: zero rate never starts a packet
    h0 = hs_count;
    run(20, 16'h0000, 2'd0, 1'b1);
    chk(hs_count == h0, "R2 zero rate is silent", 32'(hs_count), 32'(h0));

    // R3, R4: fixed patterns, diagonal node must stay silent
    diag_watch = 1'b1;
    run(150, 16'h4000, 2'd1, 1'b1);
    run(150, 16'h8000, 2'd2, 1'b1);
    diag_watch = 1'b0;
    chk(diag_hits == 0, "R4 self destination suppressed", 32'(diag_hits), 32'd0);

    // R3, R5: uniform destinations reach every hop direction
    run(300, 16'hC000, 2'd0, 1'b1);

    // R4: idle pattern stops new packets
    run(10, 16'hFFFF, 2'd3, 1'b1);
    h0 = hs_count;
    run(30, 16'hFFFF, 2'd3, 1'b1);
    chk(hs_count == h0, "R4 idle pattern is silent", 32'(hs_count), 32'(h0));
    chk(exp_q.size() == 0, "R12 all expected flits delivered", 32'(exp_q.size()), 32'd0);
    chk(n_cmp > 60, "R6 scoreboard saw traffic", 32'(n_cmp), 32'd60);

    // R9, R10: back-pressure fills the queue with whole packets only
    sb_on = 1'b0;
    run(60, 16'hFFFF, 2'd2, 1'b0);
    #1;
    held = f_data;
    chk(f_valid == 1'b1, "R10 valid held while stalled", 32'(f_valid), 32'd1);
    run(1, 16'hFFFF, 2'd2, 1'b0);
    #1;
    chk(f_data == held, "R10 data stable while stalled", 32'(f_data), 32'(held));
    chk(f_valid == 1'b1, "R10 valid still held", 32'(f_valid), 32'd1);
    chk(thr_flits == 0, "R10 nothing leaves without ready", 32'(thr_flits), 32'd0);
    run(30, 16'hFFFF, 2'd3, 1'b1);
    chk(thr_flits == 16, "R9 queue held a full load", 32'(thr_flits), 32'd16);
    chk(thr_heads == 4, "R9 only whole packets queued", 32'(thr_heads), 32'd4);
    chk(f_valid == 1'b0, "R9 queue drained", 32'(f_valid), 32'd0);

    finish_up();
  end
endmodule